// File: doc/BRIEF.md
# Command/Response Exchange Engine

This block is the host-facing command engine of a security-module interface. A bus bridge in front of it turns committed bus transactions into three kinds of strobe: a status write, a push of one byte into the command buffer, and a pop of one byte from the response buffer. The engine owns a 32-byte command buffer, a 32-byte response buffer and a five-state control machine with the states Idle, Ready, Receiving, Executing and Completed. It reports a status byte and a burst count, and it drives an active-low completion interrupt.

Behind the engine sits an execution unit, which is abstract here. When the host sets the go bit on a complete command, the engine pulses a start strobe. The execution unit then reads the command bytes, pushes the response bytes and signals done. A command-ready write acts differently in each state: it can open the engine for a new command, abort reception, abort execution, or discard a finished response. A retry write replays the response from its first byte.

Top module: `cmdrsp_engine`

## Requirements
- R1: After reset the engine is Idle. The status byte reads 0x80, the burst count is 0 and irq_n is high. Status bit positions: 7 valid (clear only while Executing), 6 command-ready (reads 1 only in Ready), 5 go (write-only), 4 data-available, 3 expect, 1 retry (write-only).
- R2: A status write with bit 6 set moves the engine from Idle to Ready, where the status byte reads 0xC0.
- R3: A status write with bit 6 set while in Ready has no effect, and the status byte stays 0xC0.
- R4: A command push in Ready stores the byte and enters Receiving. A push in Receiving stores the byte while fewer than 32 are held. Any other push is dropped.
- R5: The burst count equals 32 minus the stored command bytes while Receiving, equals the unread response bytes while Completed, and is 0 in every other state.
- R6: While Receiving, expect (bit 3) stays set until at least 6 bytes are held and the held count has reached the length field. The length field is the big-endian 32-bit value in command bytes 2 to 5.
- R7: A status write with bit 5 set while Receiving with expect clear enters Executing and pulses eng_start for one cycle. With expect set, the go bit is ignored.
- R8: A command-ready write while Receiving empties the command buffer and returns to Idle.
- R9: A command-ready write while Executing pulses eng_abort, empties both buffers and returns to Idle. It wins over an eng_done in the same cycle.
- R10: eng_done while Executing enters Completed. Host pops return the response bytes in the order pushed. irq_n is low exactly while Completed with unread bytes (valid and data-available both set) and returns high when the last byte is popped.
- R11: A status write with bit 1 set while Completed restarts the response from its first byte, restoring the burst count and data-available.
- R12: A command-ready write while Completed empties both buffers and returns to Idle with irq_n high.
- R13: A command-ready write takes priority over a command push or response pop in the same cycle, and that push or pop is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | 8 | Status write data (bits 6, 5, 1 act) |
| cmd_push | input | 1 | Command byte push strobe |
| cmd_byte | input | 8 | Command byte to push |
| rsp_pop | input | 1 | Response byte pop strobe |
| rsp_byte | output | 8 | Current response byte (0 when none left) |
| sts_byte | output | 8 | Status byte |
| burst | output | 6 | Burst count |
| irq_n | output | 1 | Active-low completion interrupt |
| eng_start | output | 1 | One-cycle start pulse to execution unit |
| eng_abort | output | 1 | One-cycle abort pulse to execution unit |
| eng_cmd_pop | input | 1 | Execution unit pops a command byte |
| eng_cmd_byte | output | 8 | Current command byte for execution unit |
| eng_rsp_valid | input | 1 | Execution unit pushes a response byte |
| eng_rsp_byte | input | 8 | Response byte from execution unit |
| eng_done | input | 1 | Execution finished |

## Verification
Two functions can fall in the same cycle: a host command-ready write together with a byte push during Receiving, and a command-ready write together with eng_done during Executing. The bench drives each pair in the same clock. It then judges the outcome at the ports: the status byte must be back at Idle with no interrupt, and a fresh command must show a burst count of 31 and deliver its own first byte to the execution unit. A fresh empty-response run must show data-available clear, which proves the aborted response bytes were discarded.

// File: rtl/cre_pkg.sv
package cre_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READY = 3'd1,
    ST_RECV  = 3'd2,
    ST_EXEC  = 3'd3,
    ST_DONE  = 3'd4
  } cre_state_e;

  localparam int B_VALID  = 7;
  localparam int B_CMDRDY = 6;
  localparam int B_GO     = 5;
  localparam int B_DAVAIL = 4;
  localparam int B_EXPECT = 3;
  localparam int B_RETRY  = 1;

  // command length field occupies byte positions LEN_FIRST..LEN_LAST, MSB first
  localparam int LEN_FIRST = 2;
  localparam int LEN_LAST  = 5;
endpackage

// File: rtl/cre_buf.sv
module cre_buf #(
  parameter  int DEPTH = 32,
  parameter  int W     = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  input  logic             rewind,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] level,
  output logic [CNT_W-1:0] avail
);
  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] wr_cnt, rd_cnt;
  logic             push_ok, pop_ok;

  assign push_ok = push && (wr_cnt < CNT_W'(DEPTH));
  assign pop_ok  = pop && (rd_cnt < wr_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt <= '0;
      rd_cnt <= '0;
    end else if (clr) begin
      wr_cnt <= '0;
      rd_cnt <= '0;
    end else begin
      if (push_ok) wr_cnt <= wr_cnt + 1'b1;
      if (rewind)      rd_cnt <= '0;
      else if (pop_ok) rd_cnt <= rd_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_cnt[IDX_W-1:0]] <= din;
  end

  assign level = wr_cnt;
  assign avail = wr_cnt - rd_cnt;
  assign dout  = (rd_cnt < wr_cnt) ? mem[rd_cnt[IDX_W-1:0]] : '0;

  // R4: stored count never exceeds the depth
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt <= CNT_W'(DEPTH));
  a_r10_read_behind_write: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= wr_cnt);
  a_r11_rewind_start: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind && !clr) |=> (rd_cnt == '0));
endmodule

// File: rtl/cre_fsm.sv
module cre_fsm
  import cre_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cr_req,
  input  logic       go_req,
  input  logic       retry_req,
  input  logic       push_req,
  input  logic       exec_done,
  input  logic       expect_pend,
  output cre_state_e state,
  output logic       ev_push_ok,
  output logic       ev_go,
  output logic       ev_recv_abort,
  output logic       ev_exec_abort,
  output logic       ev_done_clear,
  output logic       ev_retry,
  output logic       start_pulse,
  output logic       abort_pulse
);
  cre_state_e nxt;

  assign ev_push_ok    = push_req && !cr_req && (state == ST_READY || state == ST_RECV);
  assign ev_go         = go_req && !cr_req && (state == ST_RECV) && !expect_pend;
  assign ev_recv_abort = cr_req && (state == ST_RECV);
  assign ev_exec_abort = cr_req && (state == ST_EXEC);
  assign ev_done_clear = cr_req && (state == ST_DONE);
  assign ev_retry      = retry_req && !cr_req && (state == ST_DONE);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (cr_req) nxt = ST_READY;
      ST_READY: if (ev_push_ok) nxt = ST_RECV;
      ST_RECV: begin
        if (ev_recv_abort) nxt = ST_IDLE;
        else if (ev_go)    nxt = ST_EXEC;
      end
      ST_EXEC: begin
        if (ev_exec_abort)  nxt = ST_IDLE;
        else if (exec_done) nxt = ST_DONE;
      end
      ST_DONE:  if (ev_done_clear) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      start_pulse <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      state       <= nxt;
      start_pulse <= ev_go;
      abort_pulse <= ev_exec_abort;
    end
  end

  a_r2_idle_to_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cr_req) |=> (state == ST_READY));
  a_r3_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READY && cr_req) |=> (state == ST_READY));
  a_r7_start_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (state == ST_EXEC));
  a_r9_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (state == ST_IDLE));
  a_r12_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && cr_req) |=> (state == ST_IDLE));
endmodule

// File: rtl/cmdrsp_engine.sv
module cmdrsp_engine
  import cre_pkg::*;
#(
  parameter  int CMD_DEPTH = 32,
  parameter  int RSP_DEPTH = 32,
  localparam int MAX_DEPTH = (CMD_DEPTH > RSP_DEPTH) ? CMD_DEPTH : RSP_DEPTH,
  localparam int BC_W      = $clog2(MAX_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sts_we,
  input  logic [7:0]      sts_wdata,
  input  logic            cmd_push,
  input  logic [7:0]      cmd_byte,
  input  logic            rsp_pop,
  output logic [7:0]      rsp_byte,
  output logic [7:0]      sts_byte,
  output logic [BC_W-1:0] burst,
  output logic            irq_n,
  output logic            eng_start,
  output logic            eng_abort,
  input  logic            eng_cmd_pop,
  output logic [7:0]      eng_cmd_byte,
  input  logic            eng_rsp_valid,
  input  logic [7:0]      eng_rsp_byte,
  input  logic            eng_done
);
  localparam int CMD_CW = $clog2(CMD_DEPTH + 1);
  localparam int RSP_CW = $clog2(RSP_DEPTH + 1);

  cre_state_e        state;
  logic              cr_req, go_req, retry_req;
  logic              ev_push_ok, ev_go, ev_recv_abort, ev_exec_abort, ev_done_clear, ev_retry;
  logic              expect_pend, cmd_clr, rsp_clr, valid_bit, davail_bit;
  logic              rsp_push_ok, rsp_pop_ok, cmd_pop_ok;
  logic [CMD_CW-1:0] cmd_level, cmd_avail_unused;
  logic [RSP_CW-1:0] rsp_avail, rsp_level_unused;
  logic [31:0]       len_q;
  logic              unused_wbits;

  // arithmetic kept in functions so it reads as a rule
  function automatic logic hdr_pending(input logic [CMD_CW-1:0] lvl, input logic [31:0] len);
    return (lvl < CMD_CW'(LEN_LAST + 1)) || ({{(32-CMD_CW){1'b0}}, lvl} < len);
  endfunction

  function automatic logic [BC_W-1:0] burst_of(input cre_state_e st,
                                               input logic [CMD_CW-1:0] cl,
                                               input logic [RSP_CW-1:0] ra);
    case (st)
      ST_RECV: return BC_W'(CMD_DEPTH) - BC_W'(cl);
      ST_DONE: return BC_W'(ra);
      default: return '0;
    endcase
  endfunction

  assign cr_req       = sts_we && sts_wdata[B_CMDRDY];
  assign go_req       = sts_we && sts_wdata[B_GO];
  assign retry_req    = sts_we && sts_wdata[B_RETRY];
  assign unused_wbits = ^{sts_wdata[7], sts_wdata[4:2], sts_wdata[0]};

  cre_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cr_req(cr_req), .go_req(go_req), .retry_req(retry_req),
    .push_req(cmd_push), .exec_done(eng_done), .expect_pend(expect_pend), .state(state),
    .ev_push_ok(ev_push_ok), .ev_go(ev_go), .ev_recv_abort(ev_recv_abort),
    .ev_exec_abort(ev_exec_abort), .ev_done_clear(ev_done_clear), .ev_retry(ev_retry),
    .start_pulse(eng_start), .abort_pulse(eng_abort)
  );

  assign cmd_clr     = ev_recv_abort || ev_exec_abort || ev_done_clear;
  assign rsp_clr     = ev_exec_abort || ev_done_clear;
  assign cmd_pop_ok  = eng_cmd_pop && (state == ST_EXEC) && !cr_req;
  assign rsp_push_ok = eng_rsp_valid && (state == ST_EXEC) && !cr_req;
  assign rsp_pop_ok  = rsp_pop && (state == ST_DONE) && !cr_req;

  cre_buf #(.DEPTH(CMD_DEPTH), .W(8)) u_cmd_buf (
    .clk(clk), .rst_n(rst_n), .clr(cmd_clr), .push(ev_push_ok), .din(cmd_byte),
    .pop(cmd_pop_ok), .rewind(1'b0), .dout(eng_cmd_byte), .level(cmd_level),
    .avail(cmd_avail_unused)
  );

  cre_buf #(.DEPTH(RSP_DEPTH), .W(8)) u_rsp_buf (
    .clk(clk), .rst_n(rst_n), .clr(rsp_clr), .push(rsp_push_ok), .din(eng_rsp_byte),
    .pop(rsp_pop_ok), .rewind(ev_retry), .dout(rsp_byte), .level(rsp_level_unused),
    .avail(rsp_avail)
  );

  // capture the big-endian length field as its bytes arrive
  always_ff @(posedge clk) begin
    if (!rst_n || cmd_clr) begin
      len_q <= '0;
    end else if (ev_push_ok && cmd_level >= CMD_CW'(LEN_FIRST) && cmd_level <= CMD_CW'(LEN_LAST)) begin
      len_q <= {len_q[23:0], cmd_byte};
    end
  end

  assign expect_pend = (state == ST_RECV) && hdr_pending(cmd_level, len_q);
  assign valid_bit   = (state != ST_EXEC);
  assign davail_bit  = (state == ST_DONE) && (rsp_avail != '0);

  always_comb begin
    sts_byte           = '0;
    sts_byte[B_VALID]  = valid_bit;
    sts_byte[B_CMDRDY] = (state == ST_READY);
    sts_byte[B_DAVAIL] = davail_bit;
    sts_byte[B_EXPECT] = expect_pend;
  end

  assign burst = burst_of(state, cmd_level, rsp_avail);
  assign irq_n = !(valid_bit && davail_bit);

  a_r10_irq_only_done: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (state == ST_DONE));
  a_r8_recv_abort_empties: assert property (@(posedge clk) disable iff (!rst_n)
    ev_recv_abort |=> (cmd_level == '0 && state == ST_IDLE));
  a_r9_exec_abort_empties: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exec_abort |=> (rsp_avail == '0 && cmd_level == '0));
  a_r13_abort_beats_push: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECV && cr_req && cmd_push) |=> (cmd_level == '0));
  a_r5_burst_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_READY || state == ST_EXEC) |-> (burst == '0));
endmodule

// File: tb/cmdrsp_engine_test.sv
`timescale 1ns/1ps
module cmdrsp_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sts_we = 1'b0;
  logic [7:0] sts_wdata = '0;
  logic       cmd_push = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic       rsp_pop = 1'b0;
  logic [7:0] rsp_byte, sts_byte;
  logic [5:0] burst;
  logic       irq_n, eng_start, eng_abort;
  logic       eng_cmd_pop = 1'b0;
  logic [7:0] eng_cmd_byte;
  logic       eng_rsp_valid = 1'b0;
  logic [7:0] eng_rsp_byte = '0;
  logic       eng_done = 1'b0;
  int         checks = 0;
  int         errors = 0;

  cmdrsp_engine uut (
    .clk(clk), .rst_n(rst_n), .sts_we(sts_we), .sts_wdata(sts_wdata),
    .cmd_push(cmd_push), .cmd_byte(cmd_byte), .rsp_pop(rsp_pop), .rsp_byte(rsp_byte),
    .sts_byte(sts_byte), .burst(burst), .irq_n(irq_n), .eng_start(eng_start),
    .eng_abort(eng_abort), .eng_cmd_pop(eng_cmd_pop), .eng_cmd_byte(eng_cmd_byte),
    .eng_rsp_valid(eng_rsp_valid), .eng_rsp_byte(eng_rsp_byte), .eng_done(eng_done)
  );

  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_sts(input logic [7:0] v);
    sts_we = 1'b1; sts_wdata = v;
    tick();
    sts_we = 1'b0; sts_wdata = '0;
  endtask

  task automatic push(input logic [7:0] b);
    cmd_push = 1'b1; cmd_byte = b;
    tick();
    cmd_push = 1'b0;
  endtask

  // ten-byte command: length field bytes 2..5 = 0x0000000A
  function automatic logic [7:0] cmd10(input int i);
    case (i)
      0: return 8'h80; 1: return 8'hC1; 2, 3, 4: return 8'h00; 5: return 8'h0A;
      default: return 8'h30 + 8'(i);
    endcase
  endfunction

  task automatic t_reset();
    chk("R1 status", sts_byte, 8'h80);
    chk("R1 burst", burst, 0);
    chk("R1 irq_n", irq_n, 1);
  endtask

  task automatic t_push_in_idle();
    push(8'h11);
    chk("R4 idle push dropped status", sts_byte, 8'h80);
    chk("R4 idle push dropped burst", burst, 0);
  endtask

  task automatic t_ready();
    wr_sts(8'h40);
    chk("R2 idle to ready", sts_byte, 8'hC0);
    wr_sts(8'h40);
    chk("R3 ready ignore status", sts_byte, 8'hC0);
    chk("R3 ready ignore burst", burst, 0);
  endtask

  task automatic t_receive_and_go();
    push(cmd10(0));
    chk("R4 first push enters recv", sts_byte, 8'h88);
    chk("R5 burst recv", burst, 31);
    for (int i = 1; i < 9; i++) push(cmd10(i));
    chk("R6 expect held short of length", sts_byte, 8'h88);
    wr_sts(8'h20);
    chk("R7 go ignored with expect", sts_byte, 8'h88);
    chk("R7 no start with expect", eng_start, 0);
    push(cmd10(9));
    chk("R6 expect clears at length", sts_byte, 8'h80);
    chk("R5 burst after ten", burst, 22);
    wr_sts(8'h20);
    chk("R7 exec status", sts_byte, 8'h00);
    chk("R7 start pulse", eng_start, 1);
    chk("R5 burst exec", burst, 0);
    tick();
    chk("R7 start one cycle", eng_start, 0);
  endtask

  task automatic t_exec_complete();
    chk("R7 engine sees byte0", eng_cmd_byte, 8'h80);
    eng_cmd_pop = 1'b1; tick(); eng_cmd_pop = 1'b0;
    chk("R7 engine sees byte1", eng_cmd_byte, 8'hC1);
    for (int i = 0; i < 3; i++) begin
      eng_rsp_valid = 1'b1; eng_rsp_byte = 8'hA0 + 8'(i); tick();
    end
    eng_rsp_valid = 1'b0;
    chk("R10 irq high during exec", irq_n, 1);
    eng_done = 1'b1; tick(); eng_done = 1'b0;
    chk("R10 completed status", sts_byte, 8'h90);
    chk("R5 burst completed", burst, 3);
    chk("R10 irq low", irq_n, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R10 response order", rsp_byte, 8'hA0 + i);
      rsp_pop = 1'b1; tick(); rsp_pop = 1'b0;
    end
    chk("R10 irq high after drain", irq_n, 1);
    chk("R10 drained status", sts_byte, 8'h80);
    chk("R5 burst drained", burst, 0);
  endtask

  task automatic t_retry();
    wr_sts(8'h02);
    chk("R11 retry burst", burst, 3);
    chk("R11 retry first byte", rsp_byte, 8'hA0);
    chk("R11 retry irq", irq_n, 0);
    rsp_pop = 1'b1; tick(); rsp_pop = 1'b0;
    wr_sts(8'h02);
    chk("R11 retry mid-stream", rsp_byte, 8'hA0);
    chk("R11 retry mid-stream burst", burst, 3);
  endtask

  task automatic t_done_clear();
    wr_sts(8'h40);
    chk("R12 cleared status", sts_byte, 8'h80);
    chk("R12 irq high", irq_n, 1);
    wr_sts(8'h40);
    push(8'h5A);
    chk("R12 command buffer emptied", burst, 31);
  endtask

  task automatic t_recv_abort_with_push();
    push(8'h5B);
    sts_we = 1'b1; sts_wdata = 8'h40; cmd_push = 1'b1; cmd_byte = 8'h77;
    tick();
    sts_we = 1'b0; sts_wdata = '0; cmd_push = 1'b0;
    chk("R8 abort to idle", sts_byte, 8'h80);
    chk("R13 abort beats push burst", burst, 0);
    wr_sts(8'h40);
    push(8'h55);
    chk("R8 buffer emptied after abort", burst, 31);
    for (int i = 1; i < 10; i++) push(cmd10(i));
    wr_sts(8'h20);
    chk("R8 fresh command first byte", eng_cmd_byte, 8'h55);
  endtask

  task automatic t_exec_abort();
    eng_rsp_valid = 1'b1; eng_rsp_byte = 8'hEE; tick(); eng_rsp_valid = 1'b0;
    sts_we = 1'b1; sts_wdata = 8'h40; eng_done = 1'b1;
    tick();
    sts_we = 1'b0; sts_wdata = '0; eng_done = 1'b0;
    chk("R9 abort wins over done", sts_byte, 8'h80);
    chk("R9 abort pulse", eng_abort, 1);
    chk("R9 irq high", irq_n, 1);
    tick();
    chk("R9 abort one cycle", eng_abort, 0);
    wr_sts(8'h40);
    for (int i = 0; i < 10; i++) push(cmd10(i));
    wr_sts(8'h20);
    eng_done = 1'b1; tick(); eng_done = 1'b0;
    chk("R9 response emptied status", sts_byte, 8'h80);
    chk("R9 response emptied irq", irq_n, 1);
    wr_sts(8'h40);
  endtask

  task automatic t_overflow();
    wr_sts(8'h40);
    for (int i = 0; i < 34; i++) push((i == 5) ? 8'h28 : 8'h01);
    chk("R4 full buffer burst", burst, 0);
    chk("R6 expect held when length exceeds depth", sts_byte, 8'h88);
    wr_sts(8'h20);
    chk("R7 go ignored when incomplete", eng_start, 0);
    wr_sts(8'h40);
    chk("R8 abort after overflow", sts_byte, 8'h80);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_push_in_idle();
    t_ready();
    t_receive_and_go();
    t_exec_complete();
    t_retry();
    t_done_clear();
    t_recv_abort_with_push();
    t_exec_abort();
    t_overflow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule